// File: doc/BRIEF.md
# Multiplexed Serial ADC Sequencer

This block runs a 12-bit bipolar serial-output converter that sits behind an 8-to-1 analog multiplexer. A single-cycle command strobe carries a 3-bit channel number. The sequencer drives that number onto the multiplexer select lines, waits a programmable settling time, and then opens a conversion. To do that it pulls chip select low and produces a divided conversion clock. It shifts in the two's-complement result MSB first and returns it with the channel it belongs to.

Two of the multiplexer inputs are transducer disconnect-sense lines. A cable that is unplugged reads negative full scale on its sense line, and a plugged-in transducer reads about +2 V. Each finished conversion on a sense channel therefore updates a per-transducer disconnect flag from the sign of the result. The multiplexer select is interlocked with the conversion: it changes only when a command is accepted in the idle state, so it never moves while chip select is active.

The controller is a four-state machine:
- `ST_IDLE` waits for a command. On `cmd_valid` it takes transition T1 to `ST_SETTLE`.
- `ST_SETTLE` counts down the settle time. When the count reaches zero it takes transition T2 to `ST_CONVERT`.
- `ST_CONVERT` holds chip select low and toggles the clock. After the last rising edge it takes transition T3 to `ST_DONE`.
- `ST_DONE` presents the result for one cycle. It then takes transition T4 back to `ST_IDLE`.

Top module: `adc_mux_sequencer`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_sclk` are 1, while `busy`, `res_valid` and `discon_flags` are 0.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1 and the block is idle. From the next cycle, `mux_sel` equals the commanded channel and `busy` is 1.
- R3: `adc_cs_n` goes low exactly SETTLE_CYC clock cycles after the edge that accepted the command.
- R4: `adc_sclk` idles high. While `adc_cs_n` is low it toggles every DIV clock cycles, and its first transition is the falling edge that starts the conversion. Chip select stays low for exactly 2*DATA_W*DIV cycles.
- R5: `adc_dout` is sampled on each of the DATA_W rising edges of `adc_sclk`, MSB first. Chip select is released on the edge that makes the last rising edge.
- R6: `res_valid` is a one-cycle pulse that starts with the release of chip select. During the pulse, `res_data` holds the received bits (bit DATA_W-1 is the two's-complement sign) and `res_chan` holds the commanded channel.
- R7: `mux_sel` never changes while `adc_cs_n` is low.
- R8: A `cmd_valid` that arrives while `busy` is 1 is ignored: `mux_sel`, `res_chan` and the result of the running conversion are unaffected, and no extra conversion follows.
- R9: `discon_flags[i]` belongs to channel SENSE_BASE+i (channels 2 and 3 by default). It takes the sign bit of a result from that channel one cycle after that result's `res_valid`: 1 means disconnected (reading below 0 V), 0 means connected. Results from other channels leave the flags unchanged.
- R10: One cycle after `res_valid`, `busy` is 0 and a new command can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Isolated-side system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_chan | input | 3 | Channel to convert |
| busy | output | 1 | A sequence is in progress |
| mux_sel | output | 3 | Analog multiplexer select |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter clock |
| adc_dout | input | 1 | Converter serial data |
| res_valid | output | 1 | Result strobe, one cycle |
| res_data | output | 12 | Two's-complement result |
| res_chan | output | 3 | Channel of the result |
| discon_flags | output | 2 | Per-transducer disconnect flags |

## Verification
The assertions assume the converter model changes `adc_dout` only after a falling edge of `adc_sclk`, so the data is settled at every rising edge. They also assume the reset is applied before any command. The bench models the converter so that it presents a new bit only on a falling clock edge while chip select is low. It drives every command and injected strobe at the falling system-clock edge, so commands that arrive while busy occur only where the interlock must hold them off.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_DONE    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/adcseq_tick.sv
module adcseq_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(DIV + 1);
    localparam logic [TW-1:0] LAST = TW'(DIV - 1);

    logic [TW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adcseq_shift.sv
module adcseq_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (shift_en)
            q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/adcseq_discon.sv
module adcseq_discon #(
    parameter int DATA_W     = 12,
    parameter int SEL_W      = 3,
    parameter int NSENSE     = 2,
    parameter int SENSE_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [SEL_W-1:0]  chan,
    input  logic [DATA_W-1:0] data,
    output logic [NSENSE-1:0] flags
);
    for (genvar i = 0; i < NSENSE; i++) begin : g_sense
        localparam logic [SEL_W-1:0] MY_CH = SEL_W'(SENSE_BASE + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (upd && chan == MY_CH)
                flags[i] <= data[DATA_W-1];
        end
    end
endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
    import adcseq_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int SEL_W      = 3,
    parameter int SETTLE_CYC = 64,
    parameter int DIV        = 2,
    parameter int NSENSE     = 2,
    parameter int SENSE_BASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [SEL_W-1:0]  cmd_chan,
    output logic              busy,
    output logic [SEL_W-1:0]  mux_sel,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_dout,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [SEL_W-1:0]  res_chan,
    output logic [NSENSE-1:0] discon_flags
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [BW-1:0] BIT_LAST    = BW'(DATA_W - 1);

    seq_state_t       state, state_nx;
    logic [SW-1:0]    settle_cnt;
    logic [BW-1:0]    bit_cnt;
    logic [SEL_W-1:0] chan_q;
    logic             sclk_q;
    logic             tick;
    logic             rise_now;

    assign rise_now = (state == ST_CONVERT) && tick && !sclk_q;

    adcseq_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_CONVERT),
        .tick (tick)
    );

    adcseq_shift #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_SETTLE),
        .shift_en(rise_now),
        .din     (adc_dout),
        .q       (res_data)
    );

    adcseq_discon #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .NSENSE(NSENSE), .SENSE_BASE(SENSE_BASE)
    ) u_discon (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (state == ST_DONE),
        .chan (chan_q),
        .data (res_data),
        .flags(discon_flags)
    );

    // Next-state logic: T1..T4 as named in the brief
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid) state_nx = ST_SETTLE;
            ST_SETTLE:  if (settle_cnt == '0) state_nx = ST_CONVERT;
            ST_CONVERT: if (rise_now && bit_cnt == BIT_LAST) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
        endcase
    end

    // State register with its counters and channel latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            settle_cnt <= '0;
            bit_cnt    <= '0;
            chan_q     <= '0;
            sclk_q     <= 1'b1;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        chan_q     <= cmd_chan;
                        settle_cnt <= SETTLE_LAST;
                    end
                end
                ST_SETTLE: begin
                    settle_cnt <= settle_cnt - 1'b1;
                    bit_cnt    <= '0;
                    sclk_q     <= 1'b1;
                end
                ST_CONVERT: begin
                    if (tick) sclk_q <= ~sclk_q;
                    if (rise_now) bit_cnt <= bit_cnt + 1'b1;
                end
                ST_DONE: sclk_q <= 1'b1;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mux_sel  = chan_q;
        res_chan = chan_q;
        adc_sclk = sclk_q;
        unique case (state)
            ST_IDLE:    begin busy = 1'b0; adc_cs_n = 1'b1; res_valid = 1'b0; end
            ST_SETTLE:  begin busy = 1'b1; adc_cs_n = 1'b1; res_valid = 1'b0; end
            ST_CONVERT: begin busy = 1'b1; adc_cs_n = 1'b0; res_valid = 1'b0; end
            ST_DONE:    begin busy = 1'b1; adc_cs_n = 1'b1; res_valid = 1'b1; end
        endcase
    end
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             busy,
    input logic [SEL_W-1:0] mux_sel,
    input logic             adc_cs_n,
    input logic             adc_sclk,
    input logic             res_valid
);
    p_sclk_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    p_cs_released_at_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> adc_cs_n);

    p_result_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_mux_hold_in_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(mux_sel));

    p_busy_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(mux_sel));

    p_idle_after_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !busy);
endmodule

bind adc_mux_sequencer adcseq_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .busy     (busy),
    .mux_sel  (mux_sel),
    .adc_cs_n (adc_cs_n),
    .adc_sclk (adc_sclk),
    .res_valid(res_valid)
);

// File: tb/adc_mux_sequencer_tb.sv
module adc_mux_sequencer_tb;
    localparam int DATA_W = 12;
    localparam int SEL_W  = 3;
    localparam int SETTLE = 5;
    localparam int DIV    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [SEL_W-1:0]  cmd_chan = '0;
    logic              busy;
    logic [SEL_W-1:0]  mux_sel;
    logic              adc_cs_n;
    logic              adc_sclk;
    logic              adc_dout = 1'b0;
    logic              res_valid;
    logic [DATA_W-1:0] res_data;
    logic [SEL_W-1:0]  res_chan;
    logic [1:0]        discon_flags;

    logic [DATA_W-1:0] model_val = '0;
    logic [1:0]        exp_flags = '0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adc_mux_sequencer #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .SETTLE_CYC(SETTLE), .DIV(DIV),
        .NSENSE(2), .SENSE_BASE(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
        .busy(busy), .mux_sel(mux_sel), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_dout(adc_dout), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .discon_flags(discon_flags)
    );

    // Converter model: next bit presented after each falling clock edge
    initial begin
        int idx;
        idx = DATA_W - 1;
        forever begin
            @(negedge adc_sclk or posedge adc_cs_n);
            if (adc_cs_n) idx = DATA_W - 1;
            else if (idx >= 0) begin
                adc_dout = model_val[idx];
                idx = idx - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [SEL_W-1:0] ch, input logic [DATA_W-1:0] val,
                       input bit inject);
        int n;
        int low;
        int rises;
        logic prev;
        model_val = val;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_chan  = ch;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 mux_sel", 32'(mux_sel), 32'(ch));
        chk("R2 busy", 32'(busy), 1);
        n = 0;
        while (adc_cs_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 settle cycles", n, SETTLE);
        low = 0;
        rises = 0;
        prev = adc_sclk;
        chk("R4 sclk high at cs", 32'(adc_sclk), 1);
        while (!adc_cs_n && low < 1000) begin
            if (inject && low == 3) begin
                cmd_valid = 1'b1;
                cmd_chan  = ~ch;
            end else cmd_valid = 1'b0;
            @(negedge clk);
            low++;
            if (adc_sclk && !prev) rises++;
            prev = adc_sclk;
            if (!adc_cs_n && mux_sel !== ch) chk("R7 mux held", 32'(mux_sel), 32'(ch));
        end
        cmd_valid = 1'b0;
        chk("R4 cs low cycles", low, 2 * DATA_W * DIV);
        chk("R5 rising edges", rises, DATA_W);
        chk("R6 res_valid", 32'(res_valid), 1);
        chk("R6 res_data", 32'(res_data), 32'(val));
        chk("R6 res_chan", 32'(res_chan), 32'(ch));
        if (ch == 3'd2) exp_flags[0] = val[DATA_W-1];
        if (ch == 3'd3) exp_flags[1] = val[DATA_W-1];
        @(negedge clk);
        chk("R6 pulse ends", 32'(res_valid), 0);
        chk("R10 busy clear", 32'(busy), 0);
        chk("R9 discon flags", 32'(discon_flags), 32'(exp_flags));
        if (inject) begin
            @(negedge clk);
            chk("R8 no extra conversion", 32'(busy), 0);
            chk("R8 mux unchanged", 32'(mux_sel), 32'(ch));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 cs_n", 32'(adc_cs_n), 1);
        chk("R1 sclk", 32'(adc_sclk), 1);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 res_valid", 32'(res_valid), 0);
        chk("R1 flags", 32'(discon_flags), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 9; k++) begin
                logic [DATA_W-1:0] v;
                case (k)
                    0: v = 12'h000;
                    1: v = 12'h001;
                    2: v = 12'h7FF;
                    3: v = 12'h800;
                    4: v = 12'hFFF;
                    5: v = 12'h555;
                    6: v = 12'hAAA;
                    7: v = 12'(c * 12'h111 + 7);
                    default: v = 12'(12'h3E8 - c * 12'h135);
                endcase
                run(3'(c), v, (k % 3) == 1);
            end
        end
        // R9 sense flags: disconnect, reconnect, and other channels leave them
        run(3'd2, 12'h800, 1'b0);
        run(3'd3, 12'h7D0, 1'b0);
        run(3'd5, 12'hFFF, 1'b0);
        run(3'd3, 12'hF00, 1'b0);
        run(3'd2, 12'h000, 1'b0);
        run(3'd0, 12'h800, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule